// File: doc/BRIEF.md
# Configurable Oversampling UART Receiver

This block receives asynchronous serial frames on a single line. It divides the system clock by a programmable prescaler to produce an oversampling tick. Each bit period lasts a programmable number of these ticks, from 4 to 16. A falling edge on the idle-high line starts a frame and realigns both the tick divider and the oversampling counter to that edge. Each bit is then decided either from the sample at one programmable tick index, or from a 2-of-3 vote over that tick and its two neighbours.

A frame has one start bit, eight data bits with the least significant bit first, an optional parity bit (even or odd) and one stop bit. After the stop bit the received byte appears with a one-cycle valid strobe. A framing-error flag and a parity-error flag pulse in the same cycle as the strobe. A start bit that has returned high by its sample point is discarded as noise. A loop-back select feeds the local transmit line into the receiver in place of the external line, for self-test.

Top module: `uart_os_rx`

## Requirements
- R1: While reset is asserted and directly after it, `valid_o`, `frame_err_o`, `parity_err_o` are 0 and `data_o` is 0.
- R2: One bit lasts (`os_ratio_i`+1)·(`prescale_i`+1) clocks, for `os_ratio_i` from 3 to 15. The valid strobe is high exactly 3 + ((L−1)·N + N−1)·(P+1) clocks after the line falls, where N = `os_ratio_i`+1, P = `prescale_i` and L is the frame length in bits.
- R3: With `three_samp_i`=0, each bit takes the line value at tick index `samp_pos_i` (0 to N−1) of that bit. Tick 0 is the first tick of the bit. A one-tick disturbance at any other tick has no effect.
- R4: With `three_samp_i`=1, each bit is the 2-of-3 majority of ticks `samp_pos_i`−1, `samp_pos_i` and `samp_pos_i`+1 (valid for positions 1 to N−2). A single inverted tick at the sample position does not change the bit.
- R5: A frame is a low start bit, then 8 data bits with the least significant bit first, then an optional parity bit, then a stop bit. The byte is presented on `data_o`, where bit 0 is the first data bit received.
- R6: If the start bit decides high, no strobe is produced, and the receiver waits for the next falling edge.
- R7: When `parity_en_i`=1, a parity bit follows the data. The expected value is the XOR of the data bits, inverted when `parity_odd_i`=1. A mismatch sets `parity_err_o` with the strobe. When parity is disabled, `parity_err_o` stays 0.
- R8: A stop bit that decides low sets `frame_err_o` for one cycle, together with `valid_o`. The byte is still delivered.
- R9: With `loop_en_i`=1 the receiver decodes `tx_loop_i`, and traffic on `rx_i` has no effect. With `loop_en_i`=0, `tx_loop_i` is ignored.
- R10: `valid_o` is high for exactly one clock per frame, and `data_o` holds its value until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | External serial line, idle high |
| tx_loop_i | input | 1 | Local transmit line used in loop-back |
| loop_en_i | input | 1 | 1 selects `tx_loop_i` as the receive source |
| prescale_i | input | 12 | Clocks per oversampling tick minus one |
| os_ratio_i | input | 4 | Ticks per bit minus one (3..15) |
| samp_pos_i | input | 4 | Tick index of the sample point |
| three_samp_i | input | 1 | 1 selects the 3-sample majority |
| parity_en_i | input | 1 | Parity bit present |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 even |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe for a completed frame |
| frame_err_o | output | 1 | Stop bit was low; pulses with `valid_o` |
| parity_err_o | output | 1 | Parity mismatch; pulses with `valid_o` |

## Verification
An oversampling counter that slips by even one tick moves the strobe off its exact cycle, and the bench compares that cycle on every frame. In the sweeps that use the last or first tick of a bit, the same slip also corrupts the data bits. A sample tap at the wrong index shows up within one frame: a one-tick spike placed at or near the sample point either flips a data bit or fails to. A wrong state after a noise pulse would show as a spurious strobe, or as a corrupted frame that follows it.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign q_o    = chain_q[STAGES-1];
  assign fall_o = prev_q & ~q_o;

endmodule

// File: rtl/uart_os_rx_tick.sv
module uart_os_rx_tick #(
  parameter int PRESC_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               restart_i,
  input  logic [PRESC_W-1:0] prescale_i,
  output logic               tick_o
);

  logic [PRESC_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == prescale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    else                cnt_q <= '0;
  end

  // ticks are spaced prescale+1 clocks apart
  p_tick_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && prescale_i != '0) |=> !tick_o);

endmodule

// File: rtl/uart_os_rx_voter.sv
module uart_os_rx_voter #(
  parameter int OS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            smp_en_i,
  input  logic [OS_W-1:0] smp_idx_i,
  input  logic            line_i,
  input  logic [OS_W-1:0] pos_i,
  input  logic            three_i,
  output logic            bit_o
);
  import uart_os_rx_pkg::*;

  localparam int NTAP = 3;

  logic [NTAP-1:0] tap_eff;

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    logic [OS_W-1:0] idx;
    logic            hit;
    logic            t_q;
    assign idx = pos_i + OS_W'(g) - OS_W'(1);
    assign hit = smp_en_i && (smp_idx_i == idx);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  t_q <= 1'b1;
      else if (hit) t_q <= line_i;
    end
    // a tap sampled in the deciding tick is used directly
    assign tap_eff[g] = hit ? line_i : t_q;
  end

  assign bit_o = three_i ? maj3(tap_eff[0], tap_eff[1], tap_eff[2]) : tap_eff[1];

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int DATA_W      = 8,
  parameter int OS_W        = 4,
  parameter int PRESC_W     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_i,
  input  logic               tx_loop_i,
  input  logic               loop_en_i,
  input  logic [PRESC_W-1:0] prescale_i,
  input  logic [OS_W-1:0]    os_ratio_i,
  input  logic [OS_W-1:0]    samp_pos_i,
  input  logic               three_samp_i,
  input  logic               parity_en_i,
  input  logic               parity_odd_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               valid_o,
  output logic               frame_err_o,
  output logic               parity_err_o
);
  import uart_os_rx_pkg::*;

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [OS_W-1:0]   os_cnt_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_bit_q;

  logic line_sel, line_s, line_fall;
  logic active, restart, tick, smp_en, bit_end, bit_vote;
  logic [OS_W-1:0] smp_idx;

  assign line_sel = loop_en_i ? tx_loop_i : rx_i;

  uart_os_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (line_sel),
    .q_o    (line_s),
    .fall_o (line_fall)
  );

  assign active  = (state_q != ST_IDLE);
  assign restart = (state_q == ST_IDLE) && line_fall;

  uart_os_rx_tick #(.PRESC_W(PRESC_W)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (active),
    .restart_i  (restart),
    .prescale_i (prescale_i),
    .tick_o     (tick)
  );

  // the edge-detect cycle itself counts as tick 0 of the start bit
  assign smp_en  = restart | tick;
  assign smp_idx = restart ? '0 : os_cnt_q;
  assign bit_end = tick && (os_cnt_q == os_ratio_i);

  uart_os_rx_voter #(.OS_W(OS_W)) u_voter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_en_i  (smp_en),
    .smp_idx_i (smp_idx),
    .line_i    (line_s),
    .pos_i     (samp_pos_i),
    .three_i   (three_samp_i),
    .bit_o     (bit_vote)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      os_cnt_q <= '0;
    else if (restart) os_cnt_q <= OS_W'(1);
    else if (tick)    os_cnt_q <= bit_end ? '0 : os_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      bit_cnt_q    <= '0;
      shift_q      <= '0;
      par_bit_q    <= 1'b0;
      data_o       <= '0;
      valid_o      <= 1'b0;
      frame_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
    end else begin
      valid_o      <= 1'b0;
      frame_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (restart) state_q <= ST_START;
        ST_START: if (bit_end) begin
          bit_cnt_q <= '0;
          state_q   <= bit_vote ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (bit_end) begin
          shift_q   <= {bit_vote, shift_q[DATA_W-1:1]};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == LAST_BIT) state_q <= parity_en_i ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (bit_end) begin
          par_bit_q <= bit_vote;
          state_q   <= ST_STOP;
        end
        ST_STOP: if (bit_end) begin
          data_o       <= shift_q;
          valid_o      <= 1'b1;
          frame_err_o  <= ~bit_vote;
          parity_err_o <= parity_en_i && (par_bit_q != ((^shift_q) ^ parity_odd_i));
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_valid_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_frame_err_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> valid_o);

  p_parity_err_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |-> valid_o);

  p_glitch_to_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && bit_end && bit_vote) |=> (state_q == ST_IDLE && !valid_o));

  p_os_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (os_cnt_q <= os_ratio_i));

  p_idle_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !line_fall) |=> (state_q == ST_IDLE));

endmodule

// File: tb/uart_os_rx_tb_top.sv
`timescale 1ns/1ps
module uart_os_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_i = 1'b1, tx_loop_i = 1'b1, loop_en_i = 1'b0;
  logic [11:0] prescale_i = '0;
  logic [3:0]  os_ratio_i = 4'd7, samp_pos_i = 4'd3;
  logic        three_samp_i = 1'b0, parity_en_i = 1'b0, parity_odd_i = 1'b0;
  logic [7:0]  data_o;
  logic        valid_o, frame_err_o, parity_err_o;

  int checks = 0, errors = 0;
  int cyc = 0;
  int got_n = 0, got_cyc = 0;
  logic [7:0] got_d = '0;
  logic got_fe = 1'b0, got_pe = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_os_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx_i), .tx_loop_i(tx_loop_i), .loop_en_i(loop_en_i),
    .prescale_i(prescale_i), .os_ratio_i(os_ratio_i), .samp_pos_i(samp_pos_i),
    .three_samp_i(three_samp_i), .parity_en_i(parity_en_i), .parity_odd_i(parity_odd_i),
    .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o), .parity_err_o(parity_err_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      got_n++;
      got_d  = data_o;
      got_fe = frame_err_o;
      got_pe = parity_err_o;
      got_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drives one frame; spike inverts the line for one cycle at index spike (-1 none)
  task automatic frame(input logic [7:0] d, input int nos, input int pre, input int pos,
                       input logic three, input logic pen, input logic podd, input logic bad_par,
                       input logic stopv, input int spike, input logic loop,
                       input logic [7:0] exp_d, input string tag);
    logic bits [11];
    int nb, per, start, cd;
    logic pbit;
    @(negedge clk);
    rx_i = 1'b1; tx_loop_i = 1'b1;
    os_ratio_i = 4'(nos - 1); prescale_i = 12'(pre); samp_pos_i = 4'(pos);
    three_samp_i = three; parity_en_i = pen; parity_odd_i = podd; loop_en_i = loop;
    idle(4);
    pbit = (^d) ^ podd ^ bad_par;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    nb = 9;
    if (pen) begin bits[nb] = pbit; nb++; end
    bits[nb] = stopv; nb++;
    per = nos * (pre + 1);
    got_n = 0;
    start = 0;
    for (int c = 0; c < nb * per; c++) begin
      logic v;
      @(negedge clk);
      if (c == 0) start = cyc;
      v = bits[c / per] ^ (c == spike);
      if (loop) begin tx_loop_i = v; rx_i = ~v; end
      else begin rx_i = v; tx_loop_i = ~v; end
    end
    @(negedge clk);
    rx_i = 1'b1; tx_loop_i = 1'b1;
    idle(6);
    cd = ((nb - 1) * nos + nos - 1) * (pre + 1);
    chk(got_n == 1, {tag, "/R10 strobe count"}, got_n, 1);
    chk(got_d == exp_d, {tag, " data"}, got_d, exp_d);
    chk(got_fe == ~stopv, {tag, "/R8 frame_err"}, got_fe, ~stopv);
    chk(got_pe == (pen & bad_par), {tag, "/R7 parity_err"}, got_pe, pen & bad_par);
    chk(got_cyc - start == 3 + cd, {tag, "/R2 strobe cycle"}, got_cyc - start, 3 + cd);
    chk(data_o == exp_d, {tag, "/R10 data held"}, data_o, exp_d);
    loop_en_i = 1'b0;
  endtask

  task automatic glitch(input int nos, input int pos, input logic three, input int len);
    @(negedge clk);
    rx_i = 1'b1; loop_en_i = 1'b0;
    os_ratio_i = 4'(nos - 1); prescale_i = '0; samp_pos_i = 4'(pos); three_samp_i = three;
    idle(4);
    got_n = 0;
    rx_i = 1'b0;
    idle(len);
    rx_i = 1'b1;
    idle(nos * 12);
    chk(got_n == 0, "R6 glitch produced strobe", got_n, 0);
  endtask

  initial begin
    idle(3);
    chk(valid_o == 1'b0 && frame_err_o == 1'b0 && parity_err_o == 1'b0,
        "R1 flags in reset", {valid_o, frame_err_o, parity_err_o}, 0);
    chk(data_o == 8'h00, "R1 data in reset", data_o, 0);
    rst_n = 1'b1;
    idle(3);
    chk(valid_o == 1'b0 && data_o == 8'h00, "R1 after reset", data_o, 0);

    // R2 R3 R4 R5 R7: sweep over ratio, prescale, position and vote mode
    for (int nos = 4; nos <= 16; nos++)
      for (int pre = 0; pre < 2; pre++)
        for (int th = 0; th < 2; th++)
          for (int k = 0; k < 5; k++) begin
            int pos;
            logic [7:0] d;
            if (th == 1 && (k == 0 || k == 4)) continue;
            case (k)
              0: pos = 0;
              1: pos = 1;
              2: pos = nos / 2;
              3: pos = nos - 2;
              default: pos = nos - 1;
            endcase
            d = 8'((nos * 29 + pre * 71 + pos * 13 + th * 101) & 255);
            frame(d, nos, pre, pos, th[0], (nos % 3) != 0, nos[0], 1'b0, 1'b1, -1, 1'b0, d,
                  th ? "R4 sweep" : "R3 sweep");
          end

    // R3: single sample follows a spike at the sample point, ignores one beside it
    frame(8'h01, 8, 0, 4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8 + 4, 1'b0, 8'h00, "R3 spike at pos");
    frame(8'h01, 8, 0, 4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8 + 6, 1'b0, 8'h01, "R3 spike off pos");
    frame(8'hA5, 16, 1, 7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, (16 * 3 + 7) * 2, 1'b0, 8'hA1, "R3 spike bit2");
    // R4: majority masks a single-tick spike at the sample point
    frame(8'h01, 8, 0, 4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8 + 4, 1'b0, 8'h01, "R4 spike masked");
    frame(8'h00, 12, 0, 6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12 * 8 + 5, 1'b0, 8'h00, "R4 spike low side");

    // R6: start-bit noise, then a clean frame is still decoded
    glitch(8, 4, 1'b0, 4);
    glitch(8, 4, 1'b1, 3);
    glitch(16, 8, 1'b1, 8);
    frame(8'h3C, 8, 0, 4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, -1, 1'b0, 8'h3C, "R6 after glitch");

    // R7: parity errors, even and odd
    frame(8'h5A, 8, 0, 3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, -1, 1'b0, 8'h5A, "R7 bad even");
    frame(8'h5B, 8, 0, 3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, -1, 1'b0, 8'h5B, "R7 bad odd");
    frame(8'h5B, 8, 0, 3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, -1, 1'b0, 8'h5B, "R7 good odd");

    // R8: low stop bit, with and without parity
    frame(8'hC3, 8, 0, 4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0, 8'hC3, "R8 low stop");
    frame(8'h81, 10, 1, 5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, -1, 1'b0, 8'h81, "R8 low stop par");
    frame(8'h7E, 8, 0, 4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, -1, 1'b0, 8'h7E, "R8 recovery");

    // R9: loop-back decodes tx_loop_i while rx_i carries inverted traffic
    frame(8'h96, 8, 0, 4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, -1, 1'b1, 8'h96, "R9 loopback");
    frame(8'h2D, 5, 2, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, -1, 1'b1, 8'h2D, "R9 loopback 3smp");

    // R9: with loop-back on, a frame on rx_i alone yields nothing
    @(negedge clk);
    loop_en_i = 1'b1; tx_loop_i = 1'b1; rx_i = 1'b1;
    os_ratio_i = 4'd7; prescale_i = '0;
    idle(4);
    got_n = 0;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      rx_i = (c / 8 == 0) ? 1'b0 : c[3];
    end
    rx_i = 1'b1;
    idle(20);
    chk(got_n == 0, "R9 rx_i ignored in loop-back", got_n, 0);
    chk(data_o == 8'h2D, "R9 data unchanged", data_o, 8'h2D);
    loop_en_i = 1'b0;
    idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule